// File: doc/BRIEF.md
# Cache-Line Coherence State Controller

This block keeps the MESI coherence state of a small, directly indexed set of L1 lines for one core. The core presents local events with a line index and tag: load, store, explicit eviction, copy-back and invalidate cache operations. For each event the block updates the line and, when the protocol needs one, emits a single outbound coherence message one cycle later. A refill port completes an outstanding miss. While a refill is outstanding, the line is marked pending and further local requests to that index are held off.

A second port takes intervention messages from peer cores and from the I/O side. Each intervention gets a response one cycle later. The response gives the state the line held before the message (Invalid also meaning a miss), whether the line must be written back to memory, and whether its data is forwarded to the requester. A combinational lookup port lets the pipeline read the state, tag and pending flag of any index.

Top module: `coh_line_ctrl`

## Requirements
- R1: After synchronous reset every line reads Invalid (code 0) with tag 0 and no pending refill, and out_valid, rsp_valid and loc_stall are low.
- R2: A load that misses emits read-shared (out_msg 0, no data) in the next cycle and marks the index pending. A refill to it installs Shared (code 1).
- R3: A store that misses emits read-for-ownership (out_msg 1) and marks the index pending. The refill installs Exclusive (code 2). A store that then hits the Exclusive line makes it Modified (code 3) without a message.
- R4: A store hitting a Shared line emits upgrade (out_msg 2) and leaves the line Modified.
- R5: Evicting a Modified line emits write-back (out_msg 3, out_data high) and leaves it Invalid. Evicting a Shared or Exclusive line drops it silently. A load or store that misses on an index holding a Modified line of another tag is stalled for one cycle while the victim's write-back, carrying the old tag, is emitted. It then proceeds as a normal miss.
- R6: A local request is stalled, with no message and no state change, while its index has a refill pending or when an intervention targets the same index in the same cycle.
- R7: A copy-back operation hitting a Modified line emits copy-back (out_msg 4, out_data high) and leaves the line Shared. On any other line it has no effect.
- R8: A local invalidate operation always emits invalidate (out_msg 5, out_data low), and a hitting line becomes Invalid.
- R9: An inbound read-for-ownership (snp_msg 1) that hits makes the line Invalid. Write-back and forwarding are signalled only if the line was Modified.
- R10: An inbound read-shared (snp_msg 0) that hits leaves the line Shared. A Modified line also signals write-back and forwarding; an Exclusive or Shared line carries no data.
- R11: An inbound upgrade (snp_msg 2), invalidate (snp_msg 3) or I/O line injection (snp_msg 4) invalidates a hitting line and never moves data.
- R12: Every intervention is answered exactly one cycle later with the prior state (0 Invalid/miss, 1 Shared, 2 Exclusive, 3 Modified). A miss changes no line.
- R13: A refill to an index with no pending miss is ignored.
- R14: A hit requires a non-Invalid state and an equal tag. The lookup port shows the current state, tag and pending flag of the selected index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 3 | Local event: 0 load, 1 store, 2 evict, 3 copy-back, 4 invalidate |
| loc_idx | input | IDX_W | Line index of the local event |
| loc_tag | input | TAG_W | Tag of the local event |
| loc_stall | output | 1 | Local event not accepted this cycle |
| out_valid | output | 1 | Outbound coherence message valid |
| out_msg | output | 3 | Outbound message code |
| out_idx | output | IDX_W | Index of the outbound message |
| out_tag | output | TAG_W | Tag of the outbound message |
| out_data | output | 1 | Message carries line data |
| fill_valid | input | 1 | Refill arrives |
| fill_idx | input | IDX_W | Index of the refill |
| snp_valid | input | 1 | Inbound intervention present |
| snp_msg | input | 3 | Intervention code |
| snp_idx | input | IDX_W | Index of the intervention |
| snp_tag | input | TAG_W | Tag of the intervention |
| rsp_valid | output | 1 | Intervention response valid |
| rsp_prior | output | 2 | State before the intervention |
| rsp_wb | output | 1 | Line must be written back |
| rsp_fwd | output | 1 | Line data forwarded to requester |
| lkp_idx | input | IDX_W | Lookup index |
| lkp_state | output | 2 | State of the looked-up line |
| lkp_tag | output | TAG_W | Tag of the looked-up line |
| lkp_pend | output | 1 | Refill pending on the looked-up line |

## Verification
Directed sequences first take single lines through every state path: miss and refill for loads and stores, upgrade, silent Exclusive-to-Modified, copy-back, both eviction flavours and a dirty victim displaced by a miss. Each intervention type is then aimed at Modified, Exclusive and Shared lines, which separates the data-moving cases from the silent demotions and invalidations. Further probes hit a matching index with the wrong tag, refill an index with no miss, and collide a local request with an intervention on one index, so that miss, stray-fill and conflict stalling are told apart. A long random phase then mixes all three ports over few tags, so that hits, pending stalls and same-cycle collisions occur often.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        LOP_LOAD     = 3'd0,
        LOP_STORE    = 3'd1,
        LOP_EVICT    = 3'd2,
        LOP_COPYBACK = 3'd3,
        LOP_INVAL    = 3'd4
    } loc_op_t;

    typedef enum logic [2:0] {
        OM_RD_SHR   = 3'd0,
        OM_RD_OWN   = 3'd1,
        OM_UPGRADE  = 3'd2,
        OM_WRBACK   = 3'd3,
        OM_COPYBACK = 3'd4,
        OM_INVAL    = 3'd5
    } out_msg_t;

    typedef enum logic [2:0] {
        SN_RD_SHR    = 3'd0,
        SN_RD_OWN    = 3'd1,
        SN_UPGRADE   = 3'd2,
        SN_INVAL     = 3'd3,
        SN_IO_INJECT = 3'd4
    } snp_msg_t;

    typedef struct packed {
        logic     hit;
        line_st_t nxt;
        logic     wb;
        logic     fwd;
    } snp_res_t;

    typedef struct packed {
        logic     stall;
        logic     emit;
        out_msg_t msg;
        logic     use_old_tag;
        logic     data;
        logic     wr_st;
        line_st_t nxt;
        logic     wr_tag;
        logic     set_pend;
        logic     own;
    } loc_res_t;

    // Next state and data duties of a line hit by an intervention.
    function automatic snp_res_t snoop_eval(logic [2:0] msg, logic hit, line_st_t prior);
        snp_res_t r;
        r.hit = hit;
        r.nxt = prior;
        r.wb  = 1'b0;
        r.fwd = 1'b0;
        if (hit) begin
            case (snp_msg_t'(msg))
                SN_RD_SHR: begin
                    r.nxt = LS_S;
                    if (prior == LS_M) begin
                        r.wb  = 1'b1;
                        r.fwd = 1'b1;
                    end
                end
                SN_RD_OWN: begin
                    r.nxt = LS_I;
                    if (prior == LS_M) begin
                        r.wb  = 1'b1;
                        r.fwd = 1'b1;
                    end
                end
                SN_UPGRADE, SN_INVAL, SN_IO_INJECT: r.nxt = LS_I;
                default: r.nxt = prior;
            endcase
        end
        return r;
    endfunction

    // Decision for one local event against the current line.
    function automatic loc_res_t local_eval(logic [2:0] op, logic hit, line_st_t cur,
                                            logic pend, logic conflict);
        loc_res_t r;
        r = '0;
        if (pend || conflict) begin
            r.stall = 1'b1;
        end else begin
            case (loc_op_t'(op))
                LOP_LOAD, LOP_STORE: begin
                    if (!hit) begin
                        r.emit  = 1'b1;
                        r.wr_st = 1'b1;
                        r.nxt   = LS_I;
                        if (cur == LS_M) begin
                            r.stall       = 1'b1;
                            r.msg         = OM_WRBACK;
                            r.use_old_tag = 1'b1;
                            r.data        = 1'b1;
                        end else begin
                            r.msg      = (op == LOP_STORE) ? OM_RD_OWN : OM_RD_SHR;
                            r.wr_tag   = 1'b1;
                            r.set_pend = 1'b1;
                            r.own      = (op == LOP_STORE);
                        end
                    end else if (op == LOP_STORE) begin
                        if (cur == LS_S) begin
                            r.emit  = 1'b1;
                            r.msg   = OM_UPGRADE;
                            r.wr_st = 1'b1;
                            r.nxt   = LS_M;
                        end else if (cur == LS_E) begin
                            r.wr_st = 1'b1;
                            r.nxt   = LS_M;
                        end
                    end
                end
                LOP_EVICT: begin
                    if (hit) begin
                        r.wr_st = 1'b1;
                        r.nxt   = LS_I;
                        if (cur == LS_M) begin
                            r.emit = 1'b1;
                            r.msg  = OM_WRBACK;
                            r.data = 1'b1;
                        end
                    end
                end
                LOP_COPYBACK: begin
                    if (hit && cur == LS_M) begin
                        r.emit  = 1'b1;
                        r.msg   = OM_COPYBACK;
                        r.data  = 1'b1;
                        r.wr_st = 1'b1;
                        r.nxt   = LS_S;
                    end
                end
                LOP_INVAL: begin
                    r.emit = 1'b1;
                    r.msg  = OM_INVAL;
                    if (hit) begin
                        r.wr_st = 1'b1;
                        r.nxt   = LS_I;
                    end
                end
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 12,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_t         ra_st,
    output logic [TAG_W-1:0] ra_tag,
    output logic             ra_pend,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_t         rb_st,
    output logic [TAG_W-1:0] rb_tag,
    input  logic [IDX_W-1:0] rc_idx,
    output line_st_t         rc_st,
    output logic [TAG_W-1:0] rc_tag,
    output logic             rc_pend,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_st_t         sw_st,
    input  logic [IDX_W-1:0] lw_idx,
    input  logic             lw_st_en,
    input  line_st_t         lw_st,
    input  logic             lw_tag_en,
    input  logic [TAG_W-1:0] lw_tag,
    input  logic             lw_set_pend,
    input  logic             lw_own,
    input  logic             f_en,
    input  logic [IDX_W-1:0] f_idx
);

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LS_I;
                tag_q[i] <= '0;
            end
            pend_q <= '0;
            own_q  <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (f_en && f_idx == IDX_W'(i) && pend_q[i]) begin
                    st_q[i]   <= own_q[i] ? LS_E : LS_S;
                    pend_q[i] <= 1'b0;
                end else if (sw_en && sw_idx == IDX_W'(i)) begin
                    st_q[i] <= sw_st;
                end else if (lw_idx == IDX_W'(i)) begin
                    if (lw_st_en)  st_q[i]  <= lw_st;
                    if (lw_tag_en) tag_q[i] <= lw_tag;
                    if (lw_set_pend) begin
                        pend_q[i] <= 1'b1;
                        own_q[i]  <= lw_own;
                    end
                end
            end
        end
    end

    assign ra_st   = st_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign ra_pend = pend_q[ra_idx];
    assign rb_st   = st_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rc_st   = st_q[rc_idx];
    assign rc_tag  = tag_q[rc_idx];
    assign rc_pend = pend_q[rc_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  logic [2:0]       snp_msg,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             wr_en,
    output line_st_t         wr_st,
    output logic             rsp_valid,
    output logic [1:0]       rsp_prior,
    output logic             rsp_wb,
    output logic             rsp_fwd
);

    logic     hit;
    snp_res_t res;

    assign hit   = (line_st != LS_I) && (line_tag == snp_tag);
    assign res   = snoop_eval(snp_msg, hit, line_st);
    assign wr_en = snp_valid && res.hit;
    assign wr_st = res.nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_prior <= 2'd0;
            rsp_wb    <= 1'b0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= snp_valid;
            rsp_prior <= (snp_valid && hit) ? line_st : LS_I;
            rsp_wb    <= snp_valid && res.wb;
            rsp_fwd   <= snp_valid && res.fwd;
        end
    end

endmodule

// File: rtl/coh_local_unit.sv
module coh_local_unit
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 12,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_valid,
    input  logic [2:0]       loc_op,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic [TAG_W-1:0] loc_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_pend,
    input  logic             conflict,
    output logic             stall,
    output logic             st_en,
    output line_st_t         st_nxt,
    output logic             tag_en,
    output logic             set_pend,
    output logic             own,
    output logic             out_valid,
    output logic [2:0]       out_msg,
    output logic [IDX_W-1:0] out_idx,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_data
);

    logic     hit;
    loc_res_t res;

    assign hit      = (line_st != LS_I) && (line_tag == loc_tag);
    assign res      = local_eval(loc_op, hit, line_st, line_pend, conflict);
    assign stall    = loc_valid && res.stall;
    assign st_en    = loc_valid && res.wr_st;
    assign st_nxt   = res.nxt;
    assign tag_en   = loc_valid && res.wr_tag;
    assign set_pend = loc_valid && res.set_pend;
    assign own      = res.own;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_msg   <= 3'd0;
            out_idx   <= '0;
            out_tag   <= '0;
            out_data  <= 1'b0;
        end else begin
            out_valid <= loc_valid && res.emit;
            out_msg   <= res.msg;
            out_idx   <= loc_idx;
            out_tag   <= res.use_old_tag ? line_tag : loc_tag;
            out_data  <= loc_valid && res.emit && res.data;
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 12,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_valid,
    input  logic [2:0]       loc_op,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic [TAG_W-1:0] loc_tag,
    output logic             loc_stall,
    output logic             out_valid,
    output logic [2:0]       out_msg,
    output logic [IDX_W-1:0] out_idx,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_data,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             snp_valid,
    input  logic [2:0]       snp_msg,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             rsp_valid,
    output logic [1:0]       rsp_prior,
    output logic             rsp_wb,
    output logic             rsp_fwd,
    input  logic [IDX_W-1:0] lkp_idx,
    output logic [1:0]       lkp_state,
    output logic [TAG_W-1:0] lkp_tag,
    output logic             lkp_pend
);

    line_st_t         loc_st, snp_st, lkp_st;
    logic [TAG_W-1:0] loc_ltag, snp_ltag;
    logic             loc_pend;
    logic             snp_wr_en;
    line_st_t         snp_wr_st;
    logic             l_st_en, l_tag_en, l_set_pend, l_own;
    line_st_t         l_st_nxt;
    logic             conflict;

    assign conflict  = snp_valid && (snp_idx == loc_idx);
    assign lkp_state = lkp_st;

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .ra_idx     (loc_idx),
        .ra_st      (loc_st),
        .ra_tag     (loc_ltag),
        .ra_pend    (loc_pend),
        .rb_idx     (snp_idx),
        .rb_st      (snp_st),
        .rb_tag     (snp_ltag),
        .rc_idx     (lkp_idx),
        .rc_st      (lkp_st),
        .rc_tag     (lkp_tag),
        .rc_pend    (lkp_pend),
        .sw_en      (snp_wr_en),
        .sw_idx     (snp_idx),
        .sw_st      (snp_wr_st),
        .lw_idx     (loc_idx),
        .lw_st_en   (l_st_en),
        .lw_st      (l_st_nxt),
        .lw_tag_en  (l_tag_en),
        .lw_tag     (loc_tag),
        .lw_set_pend(l_set_pend),
        .lw_own     (l_own),
        .f_en       (fill_valid),
        .f_idx      (fill_idx)
    );

    coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .clk      (clk),
        .rst      (rst),
        .snp_valid(snp_valid),
        .snp_msg  (snp_msg),
        .snp_tag  (snp_tag),
        .line_st  (snp_st),
        .line_tag (snp_ltag),
        .wr_en    (snp_wr_en),
        .wr_st    (snp_wr_st),
        .rsp_valid(rsp_valid),
        .rsp_prior(rsp_prior),
        .rsp_wb   (rsp_wb),
        .rsp_fwd  (rsp_fwd)
    );

    coh_local_unit #(.LINES(LINES), .TAG_W(TAG_W)) u_local (
        .clk      (clk),
        .rst      (rst),
        .loc_valid(loc_valid),
        .loc_op   (loc_op),
        .loc_idx  (loc_idx),
        .loc_tag  (loc_tag),
        .line_st  (loc_st),
        .line_tag (loc_ltag),
        .line_pend(loc_pend),
        .conflict (conflict),
        .stall    (loc_stall),
        .st_en    (l_st_en),
        .st_nxt   (l_st_nxt),
        .tag_en   (l_tag_en),
        .set_pend (l_set_pend),
        .own      (l_own),
        .out_valid(out_valid),
        .out_msg  (out_msg),
        .out_idx  (out_idx),
        .out_tag  (out_tag),
        .out_data (out_data)
    );

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       loc_valid,
    input logic       loc_stall,
    input logic       out_valid,
    input logic [2:0] out_msg,
    input logic       out_data,
    input logic       snp_valid,
    input logic       rsp_valid,
    input logic [1:0] rsp_prior,
    input logic       rsp_wb,
    input logic       rsp_fwd
);

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        snp_valid |=> rsp_valid);

    a_r12_no_unasked_rsp: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |=> !rsp_valid);

    a_r10_data_only_from_m: assert property (@(posedge clk) disable iff (rst)
        (rsp_wb || rsp_fwd) |-> (rsp_valid && rsp_prior == 2'd3));

    a_r8_inval_dataless: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_msg == 3'd5) |-> !out_data);

    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && loc_stall) |=> (!out_valid || out_msg == 3'd3));

    a_r2_msg_needs_event: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(loc_valid));

    a_r7_data_msgs: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data) |-> (out_msg == 3'd3 || out_msg == 3'd4));

endmodule

bind coh_line_ctrl coh_line_ctrl_chk u_chk (.*);

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;

    localparam int LINES  = 8;
    localparam int TAG_W  = 12;
    localparam int IDX_W  = 3;
    localparam int CLK_NS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             loc_valid = 1'b0;
    logic [2:0]       loc_op = '0;
    logic [IDX_W-1:0] loc_idx = '0;
    logic [TAG_W-1:0] loc_tag = '0;
    logic             loc_stall;
    logic             out_valid;
    logic [2:0]       out_msg;
    logic [IDX_W-1:0] out_idx;
    logic [TAG_W-1:0] out_tag;
    logic             out_data;
    logic             fill_valid = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic             snp_valid = 1'b0;
    logic [2:0]       snp_msg = '0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic [TAG_W-1:0] snp_tag = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_prior;
    logic             rsp_wb;
    logic             rsp_fwd;
    logic [IDX_W-1:0] lkp_idx = '0;
    logic [1:0]       lkp_state;
    logic [TAG_W-1:0] lkp_tag;
    logic             lkp_pend;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model state: 0 I, 1 S, 2 E, 3 M
    int m_st [LINES];
    int m_tag[LINES];
    int m_pnd[LINES];
    int m_own[LINES];

    always #(CLK_NS/2) clk = ~clk;

    coh_line_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) u_coh_line_ctrl (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string msg_req(int m, int v);
        if (!v) return "R6";
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic string snp_req(int m, int prior);
        if (prior == 0) return "R12";
        if (m == 0) return "R10";
        if (m == 1) return "R9";
        return "R11";
    endfunction

    // one clock: check combinational outputs, predict, clock, check registers
    task automatic tick();
        int n_st[LINES];
        int n_tag[LINES];
        int n_pnd[LINES];
        int n_own[LINES];
        int e_ov, e_msg, e_oidx, e_otag, e_od;
        int e_prior, e_wb, e_fwd, e_stall;
        int li, si, fi, cur;
        bit lhit, shit;
        n_st = m_st; n_tag = m_tag; n_pnd = m_pnd; n_own = m_own;
        e_ov = 0; e_msg = 0; e_oidx = 0; e_otag = 0; e_od = 0;
        e_prior = 0; e_wb = 0; e_fwd = 0; e_stall = 0;
        lkp_idx = IDX_W'(cyc % LINES);
        #1;
        chk("R14", "lkp_state", lkp_state, m_st[lkp_idx]);
        chk("R14", "lkp_tag", lkp_tag, m_tag[lkp_idx]);
        chk("R14", "lkp_pend", lkp_pend, m_pnd[lkp_idx]);
        si = snp_idx;
        shit = m_st[si] != 0 && m_tag[si] == int'(snp_tag);
        if (snp_valid && shit) begin
            e_prior = m_st[si];
            if (snp_msg == 0) begin
                n_st[si] = 1;
                if (m_st[si] == 3) begin e_wb = 1; e_fwd = 1; end
            end else if (snp_msg == 1) begin
                n_st[si] = 0;
                if (m_st[si] == 3) begin e_wb = 1; e_fwd = 1; end
            end else if (snp_msg <= 4) begin
                n_st[si] = 0;
            end
        end
        li = loc_idx;
        cur = m_st[li];
        lhit = cur != 0 && m_tag[li] == int'(loc_tag);
        if (loc_valid) begin
            e_oidx = li;
            e_otag = loc_tag;
            if (m_pnd[li] != 0 || (snp_valid && snp_idx == loc_idx)) begin
                e_stall = 1;
            end else if ((loc_op == 0 || loc_op == 1) && !lhit && cur == 3) begin
                e_stall = 1; e_ov = 1; e_msg = 3; e_od = 1; e_otag = m_tag[li];
                n_st[li] = 0;
            end else if ((loc_op == 0 || loc_op == 1) && !lhit) begin
                e_ov = 1; e_msg = loc_op;
                n_st[li] = 0; n_tag[li] = loc_tag; n_pnd[li] = 1; n_own[li] = loc_op;
            end else if (loc_op == 1 && cur == 1) begin
                e_ov = 1; e_msg = 2; n_st[li] = 3;
            end else if (loc_op == 1 && cur == 2) begin
                n_st[li] = 3;
            end else if (loc_op == 2 && lhit) begin
                n_st[li] = 0;
                if (cur == 3) begin e_ov = 1; e_msg = 3; e_od = 1; end
            end else if (loc_op == 3 && lhit && cur == 3) begin
                e_ov = 1; e_msg = 4; e_od = 1; n_st[li] = 1;
            end else if (loc_op == 4) begin
                e_ov = 1; e_msg = 5;
                if (lhit) n_st[li] = 0;
            end
        end
        chk("R6", "loc_stall", loc_stall, e_stall);
        fi = fill_idx;
        if (fill_valid && m_pnd[fi] != 0) begin
            n_st[fi] = (m_own[fi] != 0) ? 2 : 1;
            n_pnd[fi] = 0;
        end
        @(posedge clk);
        #1;
        cyc++;
        chk(msg_req(e_msg, e_ov), "out_valid", out_valid, e_ov);
        if (e_ov != 0) begin
            chk(msg_req(e_msg, 1), "out_msg", out_msg, e_msg);
            chk(msg_req(e_msg, 1), "out_idx", out_idx, e_oidx);
            chk(msg_req(e_msg, 1), "out_tag", out_tag, e_otag);
            chk(msg_req(e_msg, 1), "out_data", out_data, e_od);
        end
        chk("R12", "rsp_valid", rsp_valid, snp_valid);
        if (snp_valid) begin
            chk(snp_req(snp_msg, e_prior), "rsp_prior", rsp_prior, e_prior);
            chk(snp_req(snp_msg, e_prior), "rsp_wb", rsp_wb, e_wb);
            chk(snp_req(snp_msg, e_prior), "rsp_fwd", rsp_fwd, e_fwd);
        end
        m_st = n_st; m_tag = n_tag; m_pnd = n_pnd; m_own = n_own;
    endtask

    task automatic idle_inputs();
        loc_valid = 0; fill_valid = 0; snp_valid = 0;
    endtask

    task automatic lcl(int op, int idx, int tag);
        idle_inputs();
        loc_valid = 1; loc_op = 3'(op); loc_idx = IDX_W'(idx); loc_tag = TAG_W'(tag);
        tick();
        idle_inputs();
    endtask

    task automatic fil(int idx);
        idle_inputs();
        fill_valid = 1; fill_idx = IDX_W'(idx);
        tick();
        idle_inputs();
    endtask

    task automatic snp(int msg, int idx, int tag);
        idle_inputs();
        snp_valid = 1; snp_msg = 3'(msg); snp_idx = IDX_W'(idx); snp_tag = TAG_W'(tag);
        tick();
        idle_inputs();
    endtask

    task automatic peek(string req, int idx, int exp_st);
        lkp_idx = IDX_W'(idx);
        #1;
        chk(req, "line state", lkp_state, exp_st);
    endtask

    // store miss, refill, store again: line ends Modified
    task automatic make_m(int idx, int tag);
        lcl(1, idx, tag);
        fil(idx);
        lcl(1, idx, tag);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_pnd[i] = 0; m_own[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1 reset state
        for (int i = 0; i < LINES; i++) begin
            lkp_idx = IDX_W'(i);
            #1;
            chk("R1", "reset state", lkp_state, 0);
            chk("R1", "reset pend", lkp_pend, 0);
        end
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset rsp_valid", rsp_valid, 0);
        chk("R1", "reset loc_stall", loc_stall, 0);

        // R2 load miss, stall while pending (R6), refill to Shared
        lcl(0, 1, 'h11);
        lcl(0, 1, 'h11);
        fil(1);
        peek("R2", 1, 1);
        // R13 stray refill
        fil(2);
        peek("R13", 2, 0);
        // R4 upgrade, R7 copy-back and no-op copy-back
        lcl(1, 1, 'h11);
        peek("R4", 1, 3);
        lcl(3, 1, 'h11);
        peek("R7", 1, 1);
        lcl(3, 1, 'h11);
        // R3 store miss, refill Exclusive, silent store
        lcl(1, 2, 'h22);
        fil(2);
        peek("R3", 2, 2);
        lcl(1, 2, 'h22);
        peek("R3", 2, 3);
        // R10 read-shared on M, tag miss (R12, R14), on E
        snp(0, 2, 'h23);
        snp(0, 2, 'h22);
        peek("R10", 2, 1);
        lcl(1, 3, 'h33);
        fil(3);
        snp(0, 3, 'h33);
        peek("R10", 3, 1);
        // R9 read-for-ownership on M and on S
        make_m(4, 'h44);
        snp(1, 4, 'h44);
        peek("R9", 4, 0);
        lcl(0, 5, 'h55);
        fil(5);
        snp(1, 5, 'h55);
        peek("R9", 5, 0);
        // R11 upgrade, invalidate, injection on M lines
        make_m(6, 'h66);
        snp(2, 6, 'h66);
        peek("R11", 6, 0);
        make_m(6, 'h67);
        snp(3, 6, 'h67);
        make_m(6, 'h68);
        snp(4, 6, 'h68);
        peek("R11", 6, 0);
        // R5 evictions and dirty victim
        lcl(2, 1, 'h11);
        peek("R5", 1, 0);
        make_m(7, 'h77);
        lcl(2, 7, 'h77);
        make_m(0, 'h01);
        lcl(0, 0, 'h02);
        peek("R5", 0, 0);
        lcl(0, 0, 'h02);
        fil(0);
        // R8 local invalidate hit and miss
        lcl(4, 3, 'h33);
        peek("R8", 3, 0);
        lcl(4, 3, 'h99);
        // R6 collision with an intervention on the same index
        idle_inputs();
        loc_valid = 1; loc_op = 3'd1; loc_idx = 3'd0; loc_tag = 12'h02;
        snp_valid = 1; snp_msg = 3'd3; snp_idx = 3'd0; snp_tag = 12'h02;
        tick();
        idle_inputs();
        peek("R6", 0, 0);

        // random traffic on all ports
        for (int n = 0; n < 3000; n++) begin
            loc_valid  = 1'($urandom % 2);
            loc_op     = 3'($urandom % 5);
            loc_idx    = IDX_W'($urandom % LINES);
            loc_tag    = TAG_W'($urandom % 3);
            fill_valid = 1'(($urandom % 3) == 0);
            fill_idx   = IDX_W'($urandom % LINES);
            snp_valid  = 1'(($urandom % 3) == 0);
            snp_msg    = 3'($urandom % 5);
            snp_idx    = IDX_W'($urandom % LINES);
            snp_tag    = TAG_W'($urandom % 3);
            tick();
        end
        idle_inputs();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 3200);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule